// File: doc/BRIEF.md
# Oversampling UART Receive Controller

This block turns an asynchronous serial line into bytes inside a synchronous clock domain. The line first passes through a two-flop synchronizer. It is then sampled only on cycles where a sample-enable tick is high, and that tick runs at eight times the bit rate. A falling line is taken as a start bit only after four low samples in a row. Because of that rule, every later sample falls close to the centre of its bit.

After the start bit is qualified, the receiver counts eight ticks for each following bit. It shifts eight data bits into a shift register, least significant bit first. On the next eighth tick it samples the stop bit and hands the byte to a holding register. The host consumes the byte with a one-cycle data-read strobe and clears the sticky error flags with a one-cycle status-read strobe. A full flag reports an unread byte. An overrun flag reports a byte lost because the holding register was still full. A framing flag reports a stop bit sampled as 0.

Top module: `uart_rx_ovs`

## Requirements
- R1: While reset is low and on the first cycle after it, `rx_full`, `overrun` and `frame_err` are 0 and `rx_byte` is 8'h00.
- R2: A start bit is accepted only after four consecutive tick samples of the synchronized line read 0. If a tick sample reads 1 before the fourth, the receiver returns to idle, and no byte, flag or data change results.
- R3: Data bit k (k = 0..7) is the line sample taken 8·(k+1) ticks after the qualifying fourth low sample. Bit k lands in `rx_byte[k]`, so the first data bit on the line is bit 0.
- R4: Because the samples are centred, frames whose bit time is 31/32 or 33/32 of the nominal eight ticks still decode correctly.
- R5: On the stop-bit sample (72 ticks after the qualifying sample), if `rx_full` is 0, the shifted byte appears on `rx_byte` and `rx_full` becomes 1 on the next cycle.
- R6: A one-cycle `rd_data` pulse clears `rx_full` to 0 on the following cycle.
- R7: If a byte completes while `rx_full` is 1 and there is no `rd_data`, then `overrun` becomes 1, `rx_byte` keeps its old value and `rx_full` stays 1.
- R8: A one-cycle `rd_stat` pulse clears `overrun` and `frame_err` to 0 and leaves `rx_full` and `rx_byte` unchanged.
- R9: If the stop-bit sample reads 0, then `frame_err` becomes 1 and the byte is still transferred as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tick8 | input | 1 | One-cycle sample enable, eight per bit time |
| rd_data | input | 1 | Host read of the received byte; clears the full flag |
| rd_stat | input | 1 | Host read of status; clears the overrun and framing flags |
| rx_byte | output | 8 | Last byte transferred into the holding register |
| rx_full | output | 1 | Holding register contains an unread byte |
| overrun | output | 1 | Sticky: a byte was dropped because the register was full |
| frame_err | output | 1 | Sticky: a stop bit was sampled as 0 |

## Verification
The assertions assume that `tick8` is a single-cycle pulse and that the host strobes are single-cycle pulses. They also assume that `rd_data` and `rd_stat` never coincide with the completion of a byte: the clear properties exclude that cycle because the setting event wins there. The stimulus keeps within these assumptions. It runs a free tick every fourth clock, which makes a bit time 32 clocks. It issues reads only well after a frame's stop sample. The framing case shortens the low stop bit so that the remaining low time cannot be mistaken for a new start bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_QUAL = 2'd1,
    RX_DATA = 2'd2
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 8,   // ticks per bit, power of two
  parameter int QUAL      = 4    // consecutive lows that qualify a start
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx,
  output rx_state_e            st_o,
  output logic [DATA_BITS-1:0] shreg_o,
  output logic                 qual_ok,
  output logic                 abort,
  output logic                 byte_done,
  output logic                 stop_bit
);

  localparam int SCW = $clog2(OVS);
  localparam int BCW = $clog2(DATA_BITS + 1);

  rx_state_e            st;
  logic [SCW-1:0]       samp_cnt;
  logic [BCW-1:0]       bit_cnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 centre;

  function automatic logic [DATA_BITS-1:0] push_lsb_first(
    input logic [DATA_BITS-1:0] cur, input logic b);
    return {b, cur[DATA_BITS-1:1]};
  endfunction

  function automatic logic at_centre(input logic [SCW-1:0] c);
    return c == SCW'(OVS - 1);
  endfunction

  always_comb begin
    qual_ok   = (st == RX_QUAL) && tick && !rx && (samp_cnt == SCW'(QUAL - 1));
    abort     = (st == RX_QUAL) && tick && rx;
    centre    = (st == RX_DATA) && tick && at_centre(samp_cnt);
    byte_done = centre && (bit_cnt == BCW'(DATA_BITS));
    stop_bit  = rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      samp_cnt <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (tick && !rx) begin
            st       <= RX_QUAL;
            samp_cnt <= SCW'(1);
          end
        end
        RX_QUAL: begin
          if (abort) begin
            st <= RX_IDLE;
          end else if (qual_ok) begin
            st       <= RX_DATA;
            samp_cnt <= '0;
            bit_cnt  <= '0;
          end else if (tick) begin
            samp_cnt <= samp_cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (tick) samp_cnt <= samp_cnt + 1'b1;
          if (centre) begin
            if (byte_done) begin
              st <= RX_IDLE;
            end else begin
              shreg   <= push_lsb_first(shreg, rx);
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign st_o    = st;
  assign shreg_o = shreg;

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_done,
  input  logic                 stop_bit,
  input  logic [DATA_BITS-1:0] shreg,
  input  logic                 rd_data,
  input  logic                 rd_stat,
  output logic [DATA_BITS-1:0] data_q,
  output logic                 full_q,
  output logic                 ovr_q,
  output logic                 ferr_q,
  output logic                 accept
);

  logic clash;

  function automatic logic slot_free(input logic full, input logic rd);
    return !full || rd;
  endfunction

  always_comb begin
    accept = byte_done && slot_free(full_q, rd_data);
    clash  = byte_done && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (accept) data_q <= shreg;

      if (accept)       full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;

      if (clash)        ovr_q <= 1'b1;
      else if (rd_stat) ovr_q <= 1'b0;

      if (byte_done && !stop_bit) ferr_q <= 1'b1;
      else if (rd_stat)           ferr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_ovs.sv
module uart_rx_ovs
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 8,
  parameter int QUAL        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic                 tick8,
  input  logic                 rd_data,
  input  logic                 rd_stat,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_full,
  output logic                 overrun,
  output logic                 frame_err
);

  logic                 rx_s;
  rx_state_e            st_w;
  logic [DATA_BITS-1:0] shreg_w;
  logic                 qual_w;
  logic                 abort_w;
  logic                 done_w;
  logic                 stop_w;
  logic                 accept_w;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (rx_line),
    .q (rx_s)
  );

  uart_rx_fsm #(.DATA_BITS(DATA_BITS), .OVS(OVS), .QUAL(QUAL)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick8),
    .rx        (rx_s),
    .st_o      (st_w),
    .shreg_o   (shreg_w),
    .qual_ok   (qual_w),
    .abort     (abort_w),
    .byte_done (done_w),
    .stop_bit  (stop_w)
  );

  uart_rx_hold #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (done_w),
    .stop_bit  (stop_w),
    .shreg     (shreg_w),
    .rd_data   (rd_data),
    .rd_stat   (rd_stat),
    .data_q    (rx_byte),
    .full_q    (rx_full),
    .ovr_q     (overrun),
    .ferr_q    (frame_err),
    .accept    (accept_w)
  );

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick8,
  input logic                 rx_s,
  input logic [1:0]           st,
  input logic [DATA_BITS-1:0] shreg,
  input logic                 done,
  input logic                 stop,
  input logic                 rd_data,
  input logic                 rd_stat,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 rx_full,
  input logic                 overrun,
  input logic                 frame_err
);

  p_abort_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_QUAL && tick8 && rx_s) |=> (st == RX_IDLE));

  p_qual_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_DATA && $past(st) != RX_DATA) |-> $past(tick8 && !rx_s));

  p_done_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == RX_DATA && tick8));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rx_full) |=> (rx_full && rx_byte == $past(shreg)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !rx_full);

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full && !rd_data) |=> (overrun && rx_full && $stable(rx_byte)));

  p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !done) |=> (!overrun && !frame_err));

  p_ferr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stop) |=> frame_err);

endmodule

bind uart_rx_ovs uart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick8     (tick8),
  .rx_s      (rx_s),
  .st        (st_w),
  .shreg     (shreg_w),
  .done      (done_w),
  .stop      (stop_w),
  .rd_data   (rd_data),
  .rd_stat   (rd_stat),
  .rx_byte   (rx_byte),
  .rx_full   (rx_full),
  .overrun   (overrun),
  .frame_err (frame_err)
);

// File: tb/uart_rx_ovs_test.sv
module uart_rx_ovs_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 8 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick8 = 1'b0;
  logic       rd_data = 1'b0;
  logic       rd_stat = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_full;
  logic       overrun;
  logic       frame_err;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  uart_rx_ovs uut (
    .clk (clk), .rst_n (rst_n), .rx_line (rx_line), .tick8 (tick8),
    .rd_data (rd_data), .rd_stat (rd_stat), .rx_byte (rx_byte),
    .rx_full (rx_full), .overrun (overrun), .frame_err (frame_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick8 = (div == TICK_DIV - 1);
      div = (div + 1) % TICK_DIV;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stopv,
                            input int bp, input int stop_len);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (bp - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx_line = b[i];
      repeat (bp - 1) @(negedge clk);
    end
    @(negedge clk);
    rx_line = stopv;
    repeat (stop_len - 1) @(negedge clk);
    @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic pulse_data();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
    idle(2);
  endtask

  task automatic pulse_stat();
    @(negedge clk); rd_stat = 1'b1;
    @(negedge clk); rd_stat = 1'b0;
    idle(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    // R1: reset values, during and right after reset
    check(rx_full, 0, "R1 full in reset");
    check(overrun, 0, "R1 overrun in reset");
    check(frame_err, 0, "R1 frame_err in reset");
    check(rx_byte, 8'h00, "R1 byte in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check({rx_byte, rx_full, overrun, frame_err}, 0, "R1 after reset");

    // R2: short low pulses (2 and at most 3 samples) are rejected
    @(negedge clk); rx_line = 1'b0; idle(8);  rx_line = 1'b1; idle(400);
    check(rx_full, 0, "R2 glitch 2 samples full");
    check(frame_err, 0, "R2 glitch 2 samples frame_err");
    @(negedge clk); rx_line = 1'b0; idle(10); rx_line = 1'b1; idle(400);
    check(rx_full, 0, "R2 glitch 3 samples full");
    check({rx_byte, overrun, frame_err}, 0, "R2 glitch no state change");

    // R3/R5/R6: every byte value, with a varying line-to-tick phase
    for (int b = 0; b < 256; b++) begin
      idle(8 + (b % TICK_DIV));
      send_frame(8'(b), 1'b1, BIT_CLKS, BIT_CLKS);
      idle(8);
      check(rx_byte, 32'(b), "R3 byte value lsb first");
      check(rx_full, 1, "R5 full set");
      check(frame_err, 0, "R9 clean stop keeps frame_err low");
      pulse_data();
      check(rx_full, 0, "R6 read clears full");
    end

    // R4: bit time off by one clock in each direction
    idle(10);
    send_frame(8'hA5, 1'b1, BIT_CLKS - 1, BIT_CLKS - 1);
    idle(8);
    check(rx_byte, 8'hA5, "R4 fast line");
    pulse_data();
    idle(10);
    send_frame(8'h3C, 1'b1, BIT_CLKS + 1, BIT_CLKS + 1);
    idle(8);
    check(rx_byte, 8'h3C, "R4 slow line");
    pulse_data();

    // R7: second byte while full is dropped
    idle(10);
    send_frame(8'h5A, 1'b1, BIT_CLKS, BIT_CLKS);
    idle(10);
    send_frame(8'hC3, 1'b1, BIT_CLKS, BIT_CLKS);
    idle(8);
    check(overrun, 1, "R7 overrun set");
    check(rx_byte, 8'h5A, "R7 old byte kept");
    check(rx_full, 1, "R7 full stays");
    pulse_stat();
    check(overrun, 0, "R8 status read clears overrun");
    check(rx_full, 1, "R8 status read keeps full");
    check(rx_byte, 8'h5A, "R8 status read keeps byte");
    pulse_data();

    // R9: stop sampled low, byte still transferred
    idle(10);
    send_frame(8'h81, 1'b0, BIT_CLKS, 20);
    idle(16);
    check(frame_err, 1, "R9 frame_err set");
    check(rx_byte, 8'h81, "R9 byte transferred");
    check(rx_full, 1, "R9 full set");
    pulse_stat();
    check(frame_err, 0, "R8 status read clears frame_err");
    pulse_data();
    idle(400);
    check(rx_full, 0, "R2 no false start after short low stop");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule